// File: doc/BRIEF.md
# Adder-Subtractor with Status Flags

A combinational integer add/subtract unit of configurable width, for use inside an execution pipeline. It takes two operands, a two-bit operation code and the carry flag that an earlier operation left behind. In the same cycle it returns the result and six status flags: carry, sign, zero, overflow, half carry (the carry out of bit 3) and parity. One binary adder serves both signed and unsigned operands. Subtraction adds the inverted second operand with the lowest carry-in forced high. The carry flag gives the unsigned reading of the result and the overflow flag gives the signed reading, so the consumer picks the flag that matches its own view of the operands.

A registered copy of the six flags is loaded whenever the input strobe is high. A later add-with-carry or subtract-with-borrow can take its carry from that copy. The parameter `BORROW_CF` sets the carry polarity of subtraction. When it is 1, the carry and half-carry flags read as borrows after a subtract, and subtract-with-borrow feeds the inverse of the incoming carry into the adder. When it is 0, both flags show the raw adder carries, and the incoming carry goes into the adder unchanged.

Top module: `alu_addsub_flags`

## Requirements
- R1: With `op_sel` = 2'b00 (add), `result` is `op_a + op_b` modulo 2^WIDTH and `carry_in` has no effect; the unit has no signed/unsigned selection.
- R2: With `op_sel` = 2'b01 (subtract), `result` is `op_a - op_b` modulo 2^WIDTH, formed as `op_a + ~op_b + 1`.
- R3: With `op_sel` = 2'b10 (add-with-carry), `result` is `op_a + op_b + carry_in`. With `op_sel` = 2'b11 (subtract-with-borrow) and `BORROW_CF` = 1, `result` is `op_a - op_b - carry_in`.
- R4: `cf` is the carry out of the top bit of the adder. On subtract and subtract-with-borrow with `BORROW_CF` = 1 it is inverted, so it reads 1 when a borrow occurs.
- R5: `of` is 1 exactly when the carry into the top bit differs from the carry out of it. For example, 8'h80 + 8'h80 gives 8'h00 with `cf` = 1 and `of` = 1.
- R6: `sf` equals the top bit of `result`, and `zf` is 1 only when every bit of `result` is 0.
- R7: `af` is the adder's carry from bit 3 into bit 4. It follows the same borrow inversion as `cf`.
- R8: `pf` is 1 when the low eight bits of `result` hold an even number of ones.
- R9: `flags_q` is 0 after reset. One cycle after a clock edge at which `in_valid` is 1, it equals the flags present at that edge, packed as {cf, sf, zf, of, af, pf} with cf in bit 5. When `in_valid` is 0, it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered flag copy |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Loads `flags_q` at the next rising edge |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand (subtrahend on subtract) |
| op_sel | input | 2 | 00 add, 01 subtract, 10 add-with-carry, 11 subtract-with-borrow |
| carry_in | input | 1 | Incoming carry flag for the carry-chained operations |
| result | output | WIDTH | Sum or difference |
| cf | output | 1 | Carry or borrow flag |
| sf | output | 1 | Sign flag |
| zf | output | 1 | Zero flag |
| of | output | 1 | Signed overflow flag |
| af | output | 1 | Half-carry flag (bit 3 to bit 4) |
| pf | output | 1 | Even-parity flag of the low byte |
| flags_q | output | 6 | Registered flags {cf, sf, zf, of, af, pf} |

## Verification
The table pairs operands that wrap the unsigned range only (8'hFF + 1) with operands that cross the signed boundary only (8'h7F + 1). It also includes 8'h80 + 8'h80, which does both, so a carry flag swapped with the overflow flag cannot pass. Subtract vectors with equal, larger and smaller subtrahends separate borrow polarity from raw carry. The carry-chained vectors run each operation with the incoming carry both low and high, which shows whether the inversion on subtract-with-borrow is applied. A plain add given a high `carry_in` shows that the carry is ignored there. Low nibbles chosen to carry or not carry, and results with odd and even bit counts, separate the half-carry and parity logic from neighbouring bits.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_SUB = 2'b01,
      OP_ADC = 2'b10,
      OP_SBB = 2'b11
   } addsub_op_e;

   typedef struct packed {
      logic cf;
      logic sf;
      logic zf;
      logic of;
      logic af;
      logic pf;
   } addsub_flags_t;

   localparam int unsigned NIBBLE_BIT = 4;
   localparam int unsigned PARITY_SPAN = 8;

endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep
   import addsub_pkg::*;
#(
   parameter int unsigned WIDTH     = 8,
   parameter bit          BORROW_CF = 1'b1
) (
   input  logic [WIDTH-1:0] op_b,
   input  logic [1:0]       op_sel,
   input  logic             carry_in,
   output logic [WIDTH-1:0] b_eff,
   output logic             cin,
   output logic             is_sub
);

   logic sbb_cin;

   // A subtract always goes through the adder, with the subtrahend inverted.
   assign is_sub = op_sel[0];
   assign b_eff  = is_sub ? ~op_b : op_b;

   generate
      if (BORROW_CF) begin : g_borrow_pol
         assign sbb_cin = ~carry_in;
      end else begin : g_raw_pol
         assign sbb_cin = carry_in;
      end
   endgenerate

   always_comb begin
      unique case (addsub_op_e'(op_sel))
         OP_ADD:  cin = 1'b0;
         OP_SUB:  cin = 1'b1;
         OP_ADC:  cin = carry_in;
         OP_SBB:  cin = sbb_cin;
         default: cin = 1'b0;
      endcase
   end

endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             c_out,
   output logic             c_msb,
   output logic             c_half
);

   localparam int unsigned HALF = addsub_pkg::NIBBLE_BIT;

   logic [WIDTH:0] carry;

   assign carry[0] = cin;

   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_bit
         assign sum[i]     = a[i] ^ b[i] ^ carry[i];
         assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
      end
      if (WIDTH > HALF) begin : g_half
         assign c_half = carry[HALF];
      end else begin : g_no_half
         assign c_half = 1'b0;
      end
   endgenerate

   assign c_out = carry[WIDTH];
   assign c_msb = carry[WIDTH-1];

endmodule

// File: rtl/addsub_flag_gen.sv
module addsub_flag_gen
   import addsub_pkg::*;
#(
   parameter int unsigned WIDTH     = 8,
   parameter bit          BORROW_CF = 1'b1
) (
   input  logic [WIDTH-1:0] sum,
   input  logic             c_out,
   input  logic             c_msb,
   input  logic             c_half,
   input  logic             is_sub,
   output addsub_flags_t    flags
);

   localparam int unsigned PW = (WIDTH < PARITY_SPAN) ? WIDTH : PARITY_SPAN;

   logic flip;

   generate
      if (BORROW_CF) begin : g_flip
         assign flip = is_sub;
      end else begin : g_noflip
         assign flip = 1'b0;
      end
   endgenerate

   always_comb begin
      flags.cf = c_out ^ flip;
      flags.sf = sum[WIDTH-1];
      flags.zf = ~|sum;
      flags.of = c_out ^ c_msb;
      flags.af = c_half ^ flip;
      flags.pf = ~^sum[PW-1:0];
   end

endmodule

// File: rtl/alu_addsub_flags.sv
module alu_addsub_flags
   import addsub_pkg::*;
#(
   parameter int unsigned WIDTH     = 8,
   parameter bit          BORROW_CF = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [1:0]       op_sel,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result,
   output logic             cf,
   output logic             sf,
   output logic             zf,
   output logic             of,
   output logic             af,
   output logic             pf,
   output logic [5:0]       flags_q
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_addsub_flags: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] b_eff;
   logic             cin;
   logic             is_sub;
   logic             c_out;
   logic             c_msb;
   logic             c_half;
   addsub_flags_t    flags;
   addsub_flags_t    flags_r;

   addsub_operand_prep #(.WIDTH(WIDTH), .BORROW_CF(BORROW_CF)) u_prep (
      .op_b     (op_b),
      .op_sel   (op_sel),
      .carry_in (carry_in),
      .b_eff    (b_eff),
      .cin      (cin),
      .is_sub   (is_sub)
   );

   addsub_ripple #(.WIDTH(WIDTH)) u_core (
      .a      (op_a),
      .b      (b_eff),
      .cin    (cin),
      .sum    (result),
      .c_out  (c_out),
      .c_msb  (c_msb),
      .c_half (c_half)
   );

   addsub_flag_gen #(.WIDTH(WIDTH), .BORROW_CF(BORROW_CF)) u_flags (
      .sum    (result),
      .c_out  (c_out),
      .c_msb  (c_msb),
      .c_half (c_half),
      .is_sub (is_sub),
      .flags  (flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_r <= '0;
      end else if (in_valid) begin
         flags_r <= flags;
      end
   end

   assign cf      = flags.cf;
   assign sf      = flags.sf;
   assign zf      = flags.zf;
   assign of      = flags.of;
   assign af      = flags.af;
   assign pf      = flags.pf;
   assign flags_q = flags_r;

endmodule

// File: rtl/addsub_flags_chk.sv
module addsub_flags_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [1:0]       op_sel,
   input logic             carry_in,
   input logic [WIDTH-1:0] result,
   input logic             cf,
   input logic             sf,
   input logic             zf,
   input logic             of,
   input logic             af,
   input logic             pf,
   input logic [5:0]       flags_q
);

   localparam int unsigned PW = (WIDTH < 8) ? WIDTH : 8;

   // R1
   p_add_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 2'b00) |-> (result == WIDTH'(op_a + op_b)));

   // R2
   p_sub_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 2'b01) |-> (result == WIDTH'(op_a - op_b)));

   // R3
   p_adc_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 2'b10) |-> (result == WIDTH'(op_a + op_b + WIDTH'(carry_in))));

   // R4
   p_add_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 2'b00) |-> (cf == ((({1'b0, op_a} + {1'b0, op_b}) >> WIDTH) != 0)));

   // R5
   p_add_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 2'b00) |->
         (of == ((op_a[WIDTH-1] == op_b[WIDTH-1]) && (result[WIDTH-1] != op_a[WIDTH-1]))));

   // R6
   p_sign_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sf == result[WIDTH-1]) && (zf == (result == '0)));

   generate
      if (WIDTH > 4) begin : g_af_chk
         // R7
         p_add_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (op_sel == 2'b00) |->
               (af == ((({1'b0, op_a[3:0]} + {1'b0, op_b[3:0]}) >> 4) != 0)));
      end
   endgenerate

   // R8
   p_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pf == ($countones(result[PW-1:0]) % 2 == 0));

   // R9
   p_flags_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (flags_q == $past({cf, sf, zf, of, af, pf})));

   // R9
   p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(flags_q));

endmodule

bind alu_addsub_flags addsub_flags_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu_addsub_flags_tb.sv
module alu_addsub_flags_tb;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic [1:0]   op_sel = 2'b00;
   logic         carry_in = 1'b0;
   logic [W-1:0] result;
   logic         cf, sf, zf, of, af, pf;
   logic [5:0]   flags_q;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   alu_addsub_flags #(.WIDTH(W), .BORROW_CF(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .op_a(op_a), .op_b(op_b), .op_sel(op_sel), .carry_in(carry_in),
      .result(result), .cf(cf), .sf(sf), .zf(zf), .of(of), .af(af), .pf(pf),
      .flags_q(flags_q)
   );

   // Entry: {op[2], carry_in, a[8], b[8], result[8], flags {cf,sf,zf,of,af,pf}}
   localparam int NV = 16;
   localparam logic [32:0] VEC [NV] = '{
      {2'b00, 1'b0, 8'hFF, 8'h01, 8'h00, 6'b101011},  // R4 R6 R7 R8 unsigned wrap
      {2'b00, 1'b0, 8'h7F, 8'h01, 8'h80, 6'b010110},  // R5 signed overflow
      {2'b00, 1'b0, 8'h80, 8'h80, 8'h00, 6'b101101},  // R5 both carry and overflow
      {2'b00, 1'b0, 8'h12, 8'h34, 8'h46, 6'b000000},  // R1 plain
      {2'b01, 1'b0, 8'h05, 8'h03, 8'h02, 6'b000000},  // R2 no borrow
      {2'b01, 1'b0, 8'h03, 8'h05, 8'hFE, 6'b110010},  // R2 R4 borrow
      {2'b01, 1'b0, 8'h80, 8'h01, 8'h7F, 6'b000110},  // R5 sub overflow
      {2'b01, 1'b0, 8'h42, 8'h42, 8'h00, 6'b001001},  // R6 zero
      {2'b10, 1'b1, 8'hFF, 8'h00, 8'h00, 6'b101011},  // R3 adc carry in
      {2'b10, 1'b0, 8'h10, 8'h20, 8'h30, 6'b000001},  // R3 R8 even parity
      {2'b11, 1'b1, 8'h10, 8'h01, 8'h0E, 6'b000010},  // R3 sbb with borrow
      {2'b11, 1'b1, 8'h00, 8'h00, 8'hFF, 6'b110011},  // R3 R4 sbb wraps
      {2'b11, 1'b0, 8'h00, 8'h00, 8'h00, 6'b001001},  // R3 sbb no borrow
      {2'b00, 1'b0, 8'h0F, 8'h01, 8'h10, 6'b000010},  // R7 half carry
      {2'b00, 1'b0, 8'h01, 8'hFE, 8'hFF, 6'b010001},  // R6 R8 sign
      {2'b00, 1'b1, 8'h01, 8'h01, 8'h02, 6'b000000}   // R1 carry_in ignored
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic string req_of(input logic [1:0] op);
      case (op)
         2'b00:   return "R1";
         2'b01:   return "R2";
         default: return "R3";
      endcase
   endfunction

   initial begin : watchdog
      #2000000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R9 reset value
      check("R9 reset", 32'(flags_q), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [32:0] v;
         v = VEC[i];
         @(negedge clk);
         op_sel   = v[32:31];
         carry_in = v[30];
         op_a     = v[29:22];
         op_b     = v[21:14];
         in_valid = 1'b1;
         #2;
         check(req_of(v[32:31]), 32'(result), 32'(v[13:6]));
         check("R4 cf", 32'(cf), 32'(v[5]));
         check("R6 sf", 32'(sf), 32'(v[4]));
         check("R6 zf", 32'(zf), 32'(v[3]));
         check("R5 of", 32'(of), 32'(v[2]));
         check("R7 af", 32'(af), 32'(v[1]));
         check("R8 pf", 32'(pf), 32'(v[0]));
         @(posedge clk);
         #2;
         check("R9 load", 32'(flags_q), 32'(v[5:0]));
      end

      // R9 hold: new inputs with strobe low leave flags_q unchanged
      @(negedge clk);
      in_valid = 1'b0;
      op_sel   = 2'b00;
      op_a     = 8'hFF;
      op_b     = 8'h01;
      repeat (2) @(posedge clk);
      #2;
      check("R9 hold", 32'(flags_q), 32'h00);

      // R9 load after hold
      @(negedge clk);
      in_valid = 1'b1;
      @(posedge clk);
      #2;
      check("R9 reload", 32'(flags_q), 32'b101011);
      @(negedge clk);
      in_valid = 1'b0;

      // R9 asynchronous reset clears the copy
      rst_n = 1'b0;
      #2;
      check("R9 async reset", 32'(flags_q), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule